// File: doc/BRIEF.md
# VLIW Cache Refill Packet Expander

This block expands compressed very-long-instruction-word code while an instruction cache line is being refilled. In memory, each long instruction is stored as a single presence mask word followed only by the operation packets that the instruction uses. When a miss request arrives, the expander reads the mask and then only the packets the mask marks as present. It then rebuilds the full-width word, with one fixed-width packet per functional-unit slot, and writes that word into the cache slices in a single cycle. The fetch path on a hit therefore only ever sees full-width, slot-aligned code.

A slot whose mask bit is clear is filled with all zeros. The functional units execute an all-zero packet as a no-op. Addresses count packet-sized memory words. The mask occupies one word, and each present packet occupies the next word in ascending slot order. The address just past the last packet read is returned with the write, so the caller knows where the next compressed instruction starts. Memory reads use a valid/ready handshake, and a beat moves only when both are high.

Top module: `vliw_refill_expander`

## Requirements
- R1: While reset is held and directly after it, `req_ready` is 1, `mem_rd_valid` is 0 and `line_we` is 0.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. In the next cycle `mem_rd_valid` is 1 with `mem_addr` equal to the accepted `req_addr` (the mask beat). `req_ready` stays 0 from then until the refill completes.
- R3: Bit i of the mask word governs slot i. Present packets are read in ascending slot order from consecutive words after the mask, and the packet for slot i lands in `line_wr_data[i*SLOT_W +: SLOT_W]`.
- R4: Every slot whose mask bit is 0 is written as all zeros, and no memory beat is spent on it.
- R5: A refill uses exactly one beat for the mask plus one beat per set mask bit. After each accepted beat that is not the last, `mem_addr` is the previous address plus one.
- R6: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, `mem_addr` and `mem_rd_valid` hold, and no packet is lost or taken twice.
- R7: `line_we` is a single-cycle pulse in the cycle after the last accepted beat, and `line_wr_data` carries the whole rebuilt word in that cycle.
- R8: With `line_we`, `next_addr` equals the start address plus one plus the number of set mask bits.
- R9: An all-zero mask produces an all-zero word, and the write follows the mask beat directly.
- R10: Slots left absent in one refill read as zero even if an earlier refill filled them.
- R11: In the cycle after `line_we`, `req_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Expander idle, can take a request |
| req_addr | input | ADDR_W | Word address of the compressed instruction's mask |
| mem_rd_valid | output | 1 | Read beat requested |
| mem_rd_ready | input | 1 | Memory returns `mem_rdata` for `mem_addr` this cycle |
| mem_addr | output | ADDR_W | Word address of the current beat |
| mem_rdata | input | SLOT_W | Mask word or packet for the current beat |
| line_we | output | 1 | Write strobe and completion pulse |
| line_wr_data | output | N_SLOTS*SLOT_W | Rebuilt full-width instruction, slot i at bits i*SLOT_W |
| next_addr | output | ADDR_W | Address after the last word consumed, valid with `line_we` |

## Verification
A corrupted pending-slot mask changes the beat count, so the write strobe appears in the wrong cycle, and it also misplaces packets; the per-cycle compare catches either within a single refill. A wrong address register shows on `mem_addr` at the very next beat. A missed clear of slot storage appears only as stale non-zero slots in the following refill's word, which is why sparse masks are run after dense ones. Stalls are inserted at random so that any advance without a handshake shows up as a shifted address in the next cycle.

// File: rtl/vliw_refill_pkg.sv
package vliw_refill_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MASK = 2'd1,
        PH_PKT  = 2'd2,
        PH_DONE = 2'd3
    } refill_phase_e;

endpackage

// File: rtl/refill_lowest_pick.sv
// Picks the lowest-numbered pending slot: index and one-hot form.
module refill_lowest_pick #(
    parameter int N_SLOTS = 32,
    parameter int IDX_W   = $clog2(N_SLOTS)
) (
    input  logic [N_SLOTS-1:0] pend,
    output logic [IDX_W-1:0]   pick_idx,
    output logic [N_SLOTS-1:0] pick_oh
);

    always_comb begin
        pick_idx = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick_idx = IDX_W'(i);
            end
        end
    end

    assign pick_oh = pend & (~pend + 1'b1);

endmodule

// File: rtl/refill_slot_bank.sv
// One register per functional-unit slot; bulk clear plus indexed write.
module refill_slot_bank #(
    parameter int SLOT_W  = 32,
    parameter int N_SLOTS = 32,
    parameter int IDX_W   = $clog2(N_SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [SLOT_W-1:0]         wr_data,
    output logic [N_SLOTS*SLOT_W-1:0] line
);

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic [SLOT_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (clr) begin
                slot_d = '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign line[g*SLOT_W +: SLOT_W] = slot_q;
    end

endmodule

// File: rtl/vliw_refill_expander.sv
module vliw_refill_expander
    import vliw_refill_pkg::*;
#(
    parameter int SLOT_W  = 32,
    parameter int N_SLOTS = 32,
    parameter int ADDR_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [ADDR_W-1:0]         req_addr,
    output logic                      mem_rd_valid,
    input  logic                      mem_rd_ready,
    output logic [ADDR_W-1:0]         mem_addr,
    input  logic [SLOT_W-1:0]         mem_rdata,
    output logic                      line_we,
    output logic [N_SLOTS*SLOT_W-1:0] line_wr_data,
    output logic [ADDR_W-1:0]         next_addr
);

    // The mask occupies the low N_SLOTS bits of one memory word.
    localparam int IDX_W = $clog2(N_SLOTS);

    typedef struct packed {
        refill_phase_e      phase;
        logic [ADDR_W-1:0]  addr;
        logic [N_SLOTS-1:0] pend;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [IDX_W-1:0]   pick_idx;
    logic [N_SLOTS-1:0] pick_oh;
    logic [N_SLOTS-1:0] mask_word;
    logic [N_SLOTS-1:0] pend_left;
    logic               bank_clr;
    logic               bank_we;

    assign mask_word = mem_rdata[N_SLOTS-1:0];
    assign pend_left = st_q.pend & ~pick_oh;

    refill_lowest_pick #(
        .N_SLOTS (N_SLOTS),
        .IDX_W   (IDX_W)
    ) pick_i (
        .pend     (st_q.pend),
        .pick_idx (pick_idx),
        .pick_oh  (pick_oh)
    );

    refill_slot_bank #(
        .SLOT_W  (SLOT_W),
        .N_SLOTS (N_SLOTS),
        .IDX_W   (IDX_W)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (bank_clr),
        .wr_en   (bank_we),
        .wr_idx  (pick_idx),
        .wr_data (mem_rdata),
        .line    (line_wr_data)
    );

    always_comb begin
        st_d     = st_q;
        bank_clr = 1'b0;
        bank_we  = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase = PH_MASK;
                    st_d.addr  = req_addr;
                end
            end
            PH_MASK: begin
                if (mem_rd_ready) begin
                    st_d.addr  = st_q.addr + ADDR_W'(1);
                    st_d.pend  = mask_word;
                    bank_clr   = 1'b1;
                    st_d.phase = (|mask_word) ? PH_PKT : PH_DONE;
                end
            end
            PH_PKT: begin
                if (mem_rd_ready) begin
                    st_d.addr = st_q.addr + ADDR_W'(1);
                    st_d.pend = pend_left;
                    bank_we   = 1'b1;
                    if (pend_left == '0) begin
                        st_d.phase = PH_DONE;
                    end
                end
            end
            PH_DONE: begin
                st_d.phase = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, addr: '0, pend: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready    = (st_q.phase == PH_IDLE);
    assign mem_rd_valid = (st_q.phase == PH_MASK) || (st_q.phase == PH_PKT);
    assign mem_addr     = st_q.addr;
    assign line_we      = (st_q.phase == PH_DONE);
    assign next_addr    = st_q.addr;

endmodule

// File: rtl/vliw_refill_expander_chk.sv
module vliw_refill_expander_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              line_we,
    input logic [ADDR_W-1:0] next_addr
);

    AST_MASK_FETCH_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd_valid && mem_addr == $past(req_addr))); // R2

    AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid || line_we) |-> !req_ready); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ready) |=>
            (!mem_rd_valid || mem_addr == $past(mem_addr) + ADDR_W'(1))); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_addr))); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        line_we |=> !line_we); // R7

    AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        line_we |-> ($past(mem_rd_valid && mem_rd_ready) &&
                     next_addr == $past(mem_addr) + ADDR_W'(1))); // R8

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        line_we |=> req_ready); // R11

endmodule

bind vliw_refill_expander vliw_refill_expander_chk #(
    .ADDR_W (ADDR_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_addr     (mem_addr),
    .line_we      (line_we),
    .next_addr    (next_addr)
);

// File: tb/vliw_refill_expander_tb_top.sv
module vliw_refill_expander_tb_top;

    localparam int SW   = 32;
    localparam int NS   = 32;
    localparam int AW   = 32;
    localparam int LW   = SW * NS;
    localparam int MEMD = 1024;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic          mem_rd_valid;
    logic          mem_rd_ready;
    logic [AW-1:0] mem_addr;
    logic [SW-1:0] mem_rdata;
    logic          line_we;
    logic [LW-1:0] line_wr_data;
    logic [AW-1:0] next_addr;

    logic [SW-1:0] mem_words [MEMD];
    int            starts [$];
    logic [AW-1:0] beat_q [$];

    int            checks = 0;
    int            errors = 0;
    int            cycles = 0;
    int            ridx   = 0;
    int            idle_cnt = 0;
    bit            exp_rr, exp_valid, exp_we, was_stalled, drop_req;
    logic [LW-1:0] exp_line;
    logic [AW-1:0] exp_next;
    logic [SW-1:0] cur_mask;

    always #2 clk = ~clk;

    assign mem_rdata = mem_words[mem_addr[9:0]];

    vliw_refill_expander #(
        .SLOT_W (SW), .N_SLOTS (NS), .ADDR_W (AW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
        .mem_rd_valid (mem_rd_valid), .mem_rd_ready (mem_rd_ready),
        .mem_addr (mem_addr), .mem_rdata (mem_rdata),
        .line_we (line_we), .line_wr_data (line_wr_data), .next_addr (next_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic add_instr(input logic [SW-1:0] m, inout int ptr);
        starts.push_back(ptr);
        mem_words[ptr] = m;
        ptr++;
        for (int s = 0; s < NS; s++) begin
            if (m[s]) begin
                mem_words[ptr] = {8'(starts.size()), 8'(s), 16'(ptr)};
                ptr++;
            end
        end
    endtask

    initial begin
        int ptr;
        logic [AW-1:0] a;
        for (int i = 0; i < MEMD; i++) mem_words[i] = 32'hDEAD0000 | 32'(i);
        ptr = 16;
        add_instr(32'hFFFF_FFFF, ptr);   // full word first, so later sparse words test R10
        add_instr(32'h0000_0000, ptr);   // R9
        add_instr(32'h0000_0000, ptr);
        add_instr(32'h8000_0001, ptr);
        add_instr(32'h0000_0001, ptr);
        add_instr(32'h8000_0000, ptr);
        add_instr(32'hAAAA_AAAA, ptr);
        add_instr(32'h5555_5555, ptr);
        add_instr(32'hFFFF_FFFF, ptr);
        add_instr(32'h0001_0000, ptr);
        for (int k = 0; k < 8; k++) add_instr($urandom(), ptr);

        req_valid = 1'b0; req_addr = '0; mem_rd_ready = 1'b0;
        exp_rr = 1'b1; exp_valid = 1'b0; exp_we = 1'b0;
        was_stalled = 1'b0; drop_req = 1'b0;
        exp_line = '0; exp_next = '0; cur_mask = '0;
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(req_ready === 1'b1,    "R1", "req_ready in reset",    LW'(req_ready), LW'(1));
            chk(mem_rd_valid === 1'b0, "R1", "mem_rd_valid in reset", LW'(mem_rd_valid), LW'(0));
            chk(line_we === 1'b0,      "R1", "line_we in reset",      LW'(line_we), LW'(0));
        end
        rst_n = 1'b1;

        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                finish_run();
            end

            // compare against the reference model
            chk(req_ready === exp_rr, "R2 R11", "req_ready", LW'(req_ready), LW'(exp_rr));
            chk(mem_rd_valid === exp_valid, "R5", "mem_rd_valid", LW'(mem_rd_valid), LW'(exp_valid));
            if (exp_valid)
                chk(mem_addr === beat_q[0], was_stalled ? "R6" : "R3 R5", "mem_addr",
                    LW'(mem_addr), LW'(beat_q[0]));
            chk(line_we === exp_we, "R7", "line_we", LW'(line_we), LW'(exp_we));
            if (exp_we) begin
                chk(line_wr_data === exp_line, (cur_mask == '0) ? "R9" : "R3 R4 R10",
                    "line_wr_data", line_wr_data, exp_line);
                chk(next_addr === exp_next, "R8", "next_addr", LW'(next_addr), LW'(exp_next));
            end

            if (ridx == starts.size() && exp_rr && !exp_we && !req_valid) begin
                idle_cnt++;
                if (idle_cnt > 4) finish_run();
            end

            // drive inputs for the next edge
            if (drop_req) begin
                req_valid = 1'b0;
                drop_req  = 1'b0;
            end
            mem_rd_ready = ($urandom_range(0, 3) != 0);
            if (!req_valid && ridx < starts.size() && $urandom_range(0, 1) == 1) begin
                req_valid = 1'b1;
                req_addr  = AW'(starts[ridx]);
            end

            // advance the reference model
            was_stalled = exp_valid && !mem_rd_ready;
            if (exp_we) begin
                exp_we = 1'b0;
                exp_rr = 1'b1;
            end else if (exp_rr && req_valid) begin
                exp_rr    = 1'b0;
                exp_valid = 1'b1;
                drop_req  = 1'b1;
                a         = req_addr;
                cur_mask  = mem_words[a[9:0]];
                beat_q    = {a};
                exp_line  = '0;
                a++;
                for (int s = 0; s < NS; s++) begin
                    if (cur_mask[s]) begin
                        beat_q.push_back(a);
                        exp_line[s*SW +: SW] = mem_words[a[9:0]];
                        a++;
                    end
                end
                exp_next = a;
                ridx++;
            end else if (exp_valid && mem_rd_ready) begin
                void'(beat_q.pop_front());
                if (beat_q.size() == 0) begin
                    exp_valid = 1'b0;
                    exp_we    = 1'b1;
                end
            end
        end
    end

endmodule